// File: doc/BRIEF.md
# SDRAM Read-to-Write Turnaround Scheduler

This block sits in the command path of an SDRAM controller. It places READ and WRITE commands on the memory command bus, and it decides on which clock a pending write may cut short a read burst that is still returning data. To interrupt a burst it raises the DQM mask early. The memory's output drivers are then off by the time the controller's own data drivers turn on, and one idle bus cycle separates the two.

Reads and writes arrive on separate valid/ready handshakes from an arbiter. A write always takes priority over a read. When a write is waiting, the block works out where the latest READ's data window ends. If that window closes early enough by itself, the WRITE simply follows it without any masking. Otherwise DQM is held high for three clocks and the WRITE is issued on the fourth clock. The first write word is driven in the same cycle as the WRITE command, and the data output enable stays high for one write burst.

CAS latency (2 or 3) and burst length (4 or 8) are configuration inputs. Both are captured when a READ is issued, and the burst length is captured again when a WRITE is issued.

Top module: `rdwr_turnaround`

## Requirements
- R1: While `rst` is high, `cmd` is NOP, `dqm` and `dq_oe` are low, and neither `rd_ready` nor `wr_ready` is asserted, whatever the request inputs are.
- R2: `cmd` encodes 2'b00 as NOP, 2'b01 as READ and 2'b10 as WRITE. A read request is granted (`rd_ready` high, `cmd` READ) in the same cycle it is presented, provided no write request is present, no DQM interruption is in progress and no write burst is on the bus.
- R3: While `wr_valid` is high, no READ command is issued and `rd_ready` stays low.
- R4: If the latest read's last data word came at least two cycles before the current cycle, a write request is granted in the cycle it is presented. In that cycle `cmd` is WRITE, `wr_ready` is high and `dq_oe` is high. `wr_ready` is never high in any other cycle.
- R5: Let a write request first appear in cycle c, after a READ in cycle t0 whose last word lands in cycle L = t0 + CL + BL - 1. If L + 2 <= c + 3, then `dqm` stays low and the WRITE is issued in cycle max(c, L + 2).
- R6: Otherwise, `dqm` is high in cycles c, c+1 and c+2, the WRITE is issued in cycle c+3, and `dqm` is low in the WRITE cycle. A WRITE therefore always comes at least one cycle after the READ it interrupts.
- R7: CL (`cfg_cl3`: 0 gives 2, 1 gives 3) and BL (`cfg_bl8`: 0 gives 4, 1 gives 8) are taken from the cycle in which the READ is issued. Changing them later does not move the read window.
- R8: `dq_oe` rises in the WRITE cycle and stays high for exactly BL cycles, where BL is read from `cfg_bl8` in the WRITE cycle.
- R9: Assume the memory stops a word when DQM was high two cycles earlier, and stops a burst at a later READ or WRITE. Under that model, `dq_oe` is never high in a cycle where the memory drives the bus, nor in the cycle just after one.
- R10: While `dq_oe` is high, no READ is granted. A read held pending is granted in the first cycle after the write burst ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cl3 | input | 1 | CAS latency select: 0 gives 2, 1 gives 3 |
| cfg_bl8 | input | 1 | Burst length select: 0 gives 4, 1 gives 8 |
| rd_valid | input | 1 | Read request from arbiter |
| rd_ready | output | 1 | Read granted; READ is on `cmd` this cycle |
| wr_valid | input | 1 | Write request from arbiter, held until granted |
| wr_ready | output | 1 | Write granted; WRITE is on `cmd` this cycle |
| cmd | output | 2 | Memory command: 00 NOP, 01 READ, 10 WRITE |
| dqm | output | 1 | Data mask to the memory |
| dq_oe | output | 1 | Controller data-bus output enable |

## Verification
Write requests are placed at chosen offsets after a READ, for each CAS latency and burst length. The offsets land on both sides of the point where the read window closes without help. They separate the immediate grant, the wait without masking and the three-clock DQM interruption. They also expose an off-by-one error in the window length or in the DQM lead. Further cases cover a configuration change after a READ (which shows whether the settings are captured at the READ), back-to-back READs (which shows that only the latest burst governs), and read and write requests held together (which exercises priority and the read grant once the write burst ends). A bus model in the bench applies DQM with its two-cycle latency and flags any cycle where memory and controller drivers overlap or touch.

// File: rtl/rdwr_pkg.sv
package rdwr_pkg;

    localparam int unsigned LO_CL    = 2;
    localparam int unsigned HI_CL    = 3;
    localparam int unsigned SHORT_BL = 4;
    localparam int unsigned LONG_BL  = 8;
    // clocks from DQM high to the memory word it suppresses
    localparam int unsigned DQM_LAT  = 2;
    // idle bus cycles between the last read word and the first write word
    localparam int unsigned BUS_GAP  = 1;
    localparam int unsigned DQM_LEAD = DQM_LAT + BUS_GAP;
    localparam int unsigned WIN_MAX  = HI_CL + LONG_BL + BUS_GAP - 1;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'b00,
        CMD_READ  = 2'b01,
        CMD_WRITE = 2'b10
    } cmd_e;

    typedef enum logic {
        TS_IDLE,
        TS_DRAIN
    } turn_e;

    typedef struct packed {
        logic rd_fire;
        logic wr_fire;
        logic masking;
    } sched_t;

    function automatic int unsigned cas_cycles(input logic cl3);
        return cl3 ? HI_CL : LO_CL;
    endfunction

    function automatic int unsigned burst_words(input logic bl8);
        return bl8 ? LONG_BL : SHORT_BL;
    endfunction

endpackage

// File: rtl/rdwr_read_window.sv
// Counts the cycles left until the bus is free of the latest read burst
// (including the idle turnaround cycle). Zero means a WRITE may go now.
module rdwr_read_window
    import rdwr_pkg::*;
#(
    parameter int unsigned GAP = BUS_GAP,
    parameter int unsigned QW  = $clog2(WIN_MAX + 1) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_fire,
    input  logic          wr_fire,
    input  logic          cfg_cl3,
    input  logic          cfg_bl8,
    output logic [QW-1:0] quiet
);

    localparam int unsigned MIN_LOAD = LO_CL + SHORT_BL + GAP - 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            quiet <= '0;
        end else if (rd_fire) begin
            quiet <= QW'(cas_cycles(cfg_cl3) + burst_words(cfg_bl8) + GAP - 1);
        end else if (wr_fire) begin
            quiet <= '0;
        end else if (quiet != '0) begin
            quiet <= quiet - 1'b1;
        end
    end

    // R7
    window_load_chk: assert property (@(posedge clk) disable iff (rst)
        rd_fire |=> (quiet >= QW'(MIN_LOAD)));

    // R5
    window_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_fire && quiet == '0) |=> (quiet == '0));

endmodule

// File: rtl/rdwr_turn_ctrl.sv
// Decides between an immediate WRITE, waiting for the burst to end,
// or a DQM interruption of DQM_LEAD clocks followed by the WRITE.
module rdwr_turn_ctrl
    import rdwr_pkg::*;
#(
    parameter int unsigned LEAD = DQM_LEAD,
    parameter int unsigned QW   = 4,
    parameter int unsigned CW   = $clog2(LEAD) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_valid,
    input  logic [QW-1:0] quiet,
    output logic          wr_fire,
    output logic          dqm,
    output logic          idle
);

    turn_e         state, state_n;
    logic [CW-1:0] dcnt, dcnt_n;

    always_comb begin
        state_n = state;
        dcnt_n  = dcnt;
        wr_fire = 1'b0;
        dqm     = 1'b0;
        if (!rst) begin
            unique case (state)
                TS_IDLE: begin
                    if (wr_valid) begin
                        if (quiet == '0) begin
                            wr_fire = 1'b1;
                        end else if (quiet > QW'(LEAD)) begin
                            dqm     = 1'b1;
                            state_n = TS_DRAIN;
                            dcnt_n  = CW'(LEAD - 1);
                        end
                    end
                end
                TS_DRAIN: begin
                    if (dcnt != '0) begin
                        dqm    = 1'b1;
                        dcnt_n = dcnt - 1'b1;
                    end else begin
                        wr_fire = wr_valid;
                        state_n = TS_IDLE;
                    end
                end
                default: state_n = TS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TS_IDLE;
            dcnt  <= '0;
        end else begin
            state <= state_n;
            dcnt  <= dcnt_n;
        end
    end

    assign idle = (state == TS_IDLE);

    // R6
    drain_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (state == TS_DRAIN && dcnt != '0) |-> dqm);

    // R6
    drain_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (state == TS_DRAIN) |-> wr_valid || dcnt == '0);

endmodule

// File: rtl/rdwr_wr_burst.sv
// Holds the controller data output enable for one write burst.
module rdwr_wr_burst
    import rdwr_pkg::*;
#(
    parameter int unsigned BW = $clog2(LONG_BL) + 1
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_fire,
    input  logic cfg_bl8,
    output logic busy,
    output logic oe
);

    logic [BW-1:0] wcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt <= '0;
        end else if (wr_fire) begin
            wcnt <= BW'(burst_words(cfg_bl8) - 1);
        end else if (wcnt != '0) begin
            wcnt <= wcnt - 1'b1;
        end
    end

    assign busy = (wcnt != '0);
    assign oe   = wr_fire | busy;

    // R8
    burst_bound_chk: assert property (@(posedge clk) disable iff (rst)
        wcnt <= BW'(LONG_BL - 1));

endmodule

// File: rtl/rdwr_turnaround.sv
module rdwr_turnaround
    import rdwr_pkg::*;
#(
    parameter int unsigned LEAD = DQM_LEAD,
    parameter int unsigned GAP  = BUS_GAP,
    parameter int unsigned QW   = $clog2(WIN_MAX + 1) + 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_cl3,
    input  logic       cfg_bl8,
    input  logic       rd_valid,
    output logic       rd_ready,
    input  logic       wr_valid,
    output logic       wr_ready,
    output logic [1:0] cmd,
    output logic       dqm,
    output logic       dq_oe
);

    sched_t        sc;
    logic [QW-1:0] quiet;
    logic          idle;
    logic          wbusy;
    cmd_e          cmd_q;

    rdwr_read_window #(.GAP(GAP), .QW(QW)) u_window (
        .clk     (clk),
        .rst     (rst),
        .rd_fire (sc.rd_fire),
        .wr_fire (sc.wr_fire),
        .cfg_cl3 (cfg_cl3),
        .cfg_bl8 (cfg_bl8),
        .quiet   (quiet)
    );

    rdwr_turn_ctrl #(.LEAD(LEAD), .QW(QW)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (wr_valid),
        .quiet    (quiet),
        .wr_fire  (sc.wr_fire),
        .dqm      (sc.masking),
        .idle     (idle)
    );

    rdwr_wr_burst u_burst (
        .clk     (clk),
        .rst     (rst),
        .wr_fire (sc.wr_fire),
        .cfg_bl8 (cfg_bl8),
        .busy    (wbusy),
        .oe      (dq_oe)
    );

    assign sc.rd_fire = !rst && rd_valid && !wr_valid && idle && !wbusy;

    always_comb begin
        if (sc.wr_fire)      cmd_q = CMD_WRITE;
        else if (sc.rd_fire) cmd_q = CMD_READ;
        else                 cmd_q = CMD_NOP;
    end

    assign cmd      = cmd_q;
    assign rd_ready = sc.rd_fire;
    assign wr_ready = sc.wr_fire;
    assign dqm      = sc.masking;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |-> (cmd == CMD_NOP && !dqm && !rd_ready && !wr_ready));

    // R3
    write_priority_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (cmd != CMD_READ));

    // R4
    grant_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_ready |-> (cmd == CMD_WRITE && dq_oe));

    // R6 (three clocks of DQM lead; LEAD default is 3)
    dqm_lead_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_WRITE && $past(dqm)) |-> ($past(dqm, 2) && $past(dqm, 3)));

    // R6
    dqm_off_at_write_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_WRITE) |-> !dqm);

    // R8
    oe_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dq_oe) |-> (cmd == CMD_WRITE));

    // R10
    no_read_in_burst_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_READ) |-> !dq_oe);

endmodule

// File: tb/rdwr_turnaround_bench.sv
module rdwr_turnaround_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_cl3 = 1'b0;
    logic       cfg_bl8 = 1'b0;
    logic       rd_valid = 1'b0;
    logic       wr_valid = 1'b0;
    logic       rd_ready, wr_ready, dqm, dq_oe;
    logic [1:0] cmd;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    int collisions = 0;
    bit done = 1'b0;

    localparam logic [1:0] C_NOP = 2'b00, C_RD = 2'b01, C_WR = 2'b10;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rdwr_turnaround u_rdwr_turnaround (
        .clk(clk), .rst(rst), .cfg_cl3(cfg_cl3), .cfg_bl8(cfg_bl8),
        .rd_valid(rd_valid), .rd_ready(rd_ready),
        .wr_valid(wr_valid), .wr_ready(wr_ready),
        .cmd(cmd), .dqm(dqm), .dq_oe(dq_oe)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Bus model: memory read words with DQM latency 2, cut by later READ/WRITE.
    bit sched [64];
    bit dqm_d1 = 1'b0, dqm_d2 = 1'b0, prev_drive = 1'b0;
    always begin
        @(negedge clk);
        #1;
        if (!rst) begin
            bit drive;
            if (cmd == C_RD) begin
                int cl = cfg_cl3 ? 3 : 2;
                int bl = cfg_bl8 ? 8 : 4;
                for (int k = 0; k < 16; k++) sched[(cyc + cl + k) % 64] = 1'b0;
                for (int k = 0; k < bl; k++) sched[(cyc + cl + k) % 64] = 1'b1;
            end
            if (cmd == C_WR)
                for (int k = 0; k < 16; k++) sched[(cyc + k) % 64] = 1'b0;
            drive = sched[cyc % 64] && !dqm_d2;
            sched[cyc % 64] = 1'b0;
            if (dq_oe && (drive || prev_drive)) begin
                collisions++;
                $display("bus overlap at cycle %0d (mem %0d, mem prev %0d)",
                         cyc, drive, prev_drive);
            end
            dqm_d2 = dqm_d1;
            dqm_d1 = dqm;
            prev_drive = drive;
        end
    end

    task automatic read_cmd(input bit cl3, input bit bl8, output int t0);
        @(negedge clk);
        cfg_cl3 = cl3; cfg_bl8 = bl8; rd_valid = 1'b1;
        #1;
        check(cmd == C_RD && rd_ready, "R2", "read grant", cmd, C_RD);
        t0 = cyc;
        @(negedge clk);
        rd_valid = 1'b0;
    endtask

    // Presents a write in cycle c and checks its timing against R4/R5/R6.
    task automatic write_at(input int c, input int t0, input int cl, input int bl,
                            input bit hold_rd, input string tg);
        int L, wnat, expw, expd, dcount, got, wbl;
        while (cyc < c) @(negedge clk);
        wr_valid = 1'b1;
        if (hold_rd) rd_valid = 1'b1;
        L = t0 + cl + bl - 1;
        wnat = L + 2;
        if (wnat <= c + 3) begin
            expw = (wnat > c) ? wnat : c;
            expd = 0;
        end else begin
            expw = c + 3;
            expd = 3;
        end
        dcount = 0; got = -1; wbl = 4;
        for (int i = 0; i < 20 && got < 0; i++) begin
            if (i > 0) @(negedge clk);
            #1;
            if (hold_rd) check(cmd != C_RD && !rd_ready, "R3", "read while write pending", cmd, C_NOP);
            if (cmd == C_WR) begin
                got = cyc;
                wbl = cfg_bl8 ? 8 : 4;
                check(wr_ready && dq_oe, "R4", "grant and oe on WRITE", wr_ready, 1);
                check(!dqm, "R6", "dqm low on WRITE", dqm, 0);
            end else begin
                if (dqm) dcount++;
                check(!wr_ready && !dq_oe, "R4", "grant or oe before WRITE", wr_ready, 0);
            end
        end
        check(got - t0 == expw - t0, tg, "WRITE cycle after READ", got - t0, expw - t0);
        check(dcount == expd, tg, "dqm cycles before WRITE", dcount, expd);
        for (int k = 1; k <= wbl; k++) begin
            @(negedge clk);
            if (k == 1) wr_valid = 1'b0;
            #1;
            check(dq_oe == (k < wbl), "R8", "dq_oe in write burst", dq_oe, k < wbl);
            if (hold_rd) begin
                if (k < wbl)
                    check(!rd_ready, "R10", "read during write burst", rd_ready, 0);
                else
                    check(rd_ready && cmd == C_RD, "R10", "read after write burst", cmd, C_RD);
            end
        end
        if (hold_rd) begin
            @(negedge clk);
            rd_valid = 1'b0;
        end
    endtask

    task automatic t_reset();
        rd_valid = 1'b1; wr_valid = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        check(cmd == C_NOP && !dqm && !dq_oe, "R1", "outputs in reset", cmd, C_NOP);
        check(!rd_ready && !wr_ready, "R1", "grants in reset", rd_ready + wr_ready, 0);
        @(negedge clk);
        rd_valid = 1'b0; wr_valid = 1'b0; rst = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_interrupt_short();
        int t0;
        read_cmd(1'b0, 1'b0, t0);
        write_at(t0 + 1, t0, 2, 4, 1'b0, "R6");
    endtask

    task automatic t_interrupt_long();
        int t0;
        read_cmd(1'b1, 1'b1, t0);
        write_at(t0 + 1, t0, 3, 8, 1'b0, "R6");
    endtask

    task automatic t_natural_cl2();
        int t0;
        read_cmd(1'b0, 1'b0, t0);
        write_at(t0 + 4, t0, 2, 4, 1'b0, "R5");
    endtask

    task automatic t_boundary_cl3();
        int t0;
        read_cmd(1'b1, 1'b0, t0);
        write_at(t0 + 4, t0, 3, 4, 1'b0, "R6");
        repeat (4) @(negedge clk);
        read_cmd(1'b1, 1'b0, t0);
        write_at(t0 + 5, t0, 3, 4, 1'b0, "R5");
    endtask

    task automatic t_cfg_capture();
        int t0;
        read_cmd(1'b0, 1'b1, t0);
        cfg_bl8 = 1'b0;
        write_at(t0 + 7, t0, 2, 8, 1'b0, "R7");
    endtask

    task automatic t_idle_bus();
        int t0;
        read_cmd(1'b0, 1'b0, t0);
        write_at(t0 + 12, t0, 2, 4, 1'b0, "R4");
    endtask

    task automatic t_priority();
        int t0;
        read_cmd(1'b0, 1'b0, t0);
        write_at(t0 + 1, t0, 2, 4, 1'b1, "R3");
        repeat (12) @(negedge clk);
    endtask

    task automatic t_back_to_back();
        int t0, t1;
        read_cmd(1'b1, 1'b1, t0);
        read_cmd(1'b0, 1'b0, t1);
        write_at(t1 + 4, t1, 2, 4, 1'b0, "R5");
    endtask

    initial begin
        t_reset();
        t_interrupt_short();
        repeat (6) @(negedge clk);
        t_interrupt_long();
        repeat (10) @(negedge clk);
        t_natural_cl2();
        repeat (6) @(negedge clk);
        t_boundary_cl3();
        repeat (6) @(negedge clk);
        t_cfg_capture();
        repeat (6) @(negedge clk);
        t_idle_bus();
        repeat (6) @(negedge clk);
        t_priority();
        t_back_to_back();
        repeat (12) @(negedge clk);
        check(collisions == 0, "R9", "bus overlap cycles", collisions, 0);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 20000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule